// File: doc/BRIEF.md
# Async receive exception character handler

This block sits between an asynchronous receiver and the receive FIFO. Each character arrives with its data bits and four condition flags: parity error, framing error, break and overrun. The block decides what, if anything, goes into the FIFO for that character. The output is a byte stream with a valid/ready handshake. The block also keeps a status word and produces a one-cycle exception strobe for the interrupt logic.

Break conditions have their own policy selector. Parity and framing errors share a second policy selector. Between them the two selectors offer five treatments:
- raise an exception and drop the character;
- replace the character with a null byte;
- pass the character unchanged;
- drop the character without reporting it;
- deliver the character behind a two-byte marker.

Before any policy is applied, the character is masked to the configured length. It can also have its top bit cleared.

A character that needs more than one output byte keeps the input side stalled until the last byte has been accepted downstream. A separate timeout pulse from the receive timer is reported through the same status word and strobe.

Top module: `rxexc_handler`

## Requirements
- R1: The character length code `cfgCharLen` selects `cfgCharLen+1` data bits. Codes 4, 5, 6 and 7 give 5, 6, 7 and 8 bits. Data bits above the selected length are delivered as zero.
- R2: When `cfgStrip` is 1, bit 7 of the delivered character byte is 0. Marker bytes are not affected.
- R3: Break policy `cfgBrkPolicy` behaves as follows:
  - code 1 delivers a single 0x00;
  - code 3 delivers nothing and raises no strobe;
  - code 0 and the unused code 2 deliver nothing, pulse `excStrobe` and set status bit 0.
- R4: Under error policy code 0, or the unused codes 4, 6 and 7, a character with an error delivers nothing. `excStrobe` pulses, status bit 1 is set for a framing error and status bit 2 for a parity error.
- R5: Error policy code 1 delivers 0x00 in place of an errored character. Code 2 delivers the character unchanged. Code 3 delivers nothing and raises no strobe.
- R6: Error policy code 5 delivers an errored character as three bytes in this order: 0xFF, 0x00, then the character.
- R7: Under error policy code 5, a clean character whose delivered value is 0xFF is sent as 0xFF followed by 0xFF.
- R8: When `cfgParCheck` is 0, the parity error flag is ignored and the character is handled as clean.
- R9: A character flagged with break is handled only by the break policy. Its framing and parity flags have no effect.
- R10: Overrun leaves the byte stream unchanged. It sets status bit 3 and pulses `excStrobe`.
- R11: A `rxTimeout` pulse sets status bit 7 and pulses `excStrobe`. The strobe and the new status word appear in the cycle after the triggering input. The status word holds the bits of the most recent event.
- R12: The first output byte is valid in the cycle after a character is accepted. `inReady` stays low until the last byte of a sequence is accepted. While `outValid` is high and `outReady` is low, `outData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Receiver offers a character |
| inReady | output | 1 | Block can take a character |
| inData | input | 8 | Received data bits |
| inParErr | input | 1 | Parity error flag |
| inFrmErr | input | 1 | Framing error flag |
| inBreak | input | 1 | Break flag |
| inOverrun | input | 1 | Overrun flag |
| rxTimeout | input | 1 | Receive timeout pulse with the FIFO empty |
| cfgCharLen | input | 3 | Character length code |
| cfgParCheck | input | 1 | 1 = parity errors are honoured |
| cfgStrip | input | 1 | 1 = clear bit 7 of the character |
| cfgBrkPolicy | input | 2 | Break treatment code |
| cfgErrPolicy | input | 3 | Parity/framing treatment code |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | FIFO accepts the byte |
| outData | output | 8 | Output byte |
| excStrobe | output | 1 | One-cycle exception pulse |
| excStatus | output | 8 | Flags of the last exception event |

## Verification
The bench builds the block with its default marker bytes, 0xFF as lead and 0x00 as fill, so the three-byte marking and the doubled 0xFF are checked against their literal values. The escape case can only be reached with an 8-bit length and strip off, and the bench checks it there. It also checks that strip removes the escape. Holding `outReady` low in the middle of a marked sequence exercises the stall of the input side and the hold of the output byte.

// File: rtl/rxexc_pkg.sv
package rxexc_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 8;
  localparam int IDX_W = 2;
  localparam int SEQ_SLOTS = 1 << IDX_W;

  // status bit positions
  localparam int ST_BRK = 0;
  localparam int ST_FRM = 1;
  localparam int ST_PAR = 2;
  localparam int ST_OVR = 3;
  localparam int ST_TMO = 7;

  // break policy codes
  localparam logic [1:0] BRK_EXC  = 2'd0;
  localparam logic [1:0] BRK_NULL = 2'd1;
  localparam logic [1:0] BRK_DROP = 2'd3;

  // parity/framing policy codes
  localparam logic [2:0] ERR_EXC    = 3'd0;
  localparam logic [2:0] ERR_NULL   = 3'd1;
  localparam logic [2:0] ERR_IGNORE = 3'd2;
  localparam logic [2:0] ERR_DROP   = 3'd3;
  localparam logic [2:0] ERR_MARK   = 3'd5;

  typedef enum logic [2:0] {
    EMIT_NONE,
    EMIT_NULL,
    EMIT_CHAR,
    EMIT_ESCFF,
    EMIT_MARKED
  } emit_e;

  typedef struct packed {
    logic              load;
    emit_e             kind;
    logic [IDX_W-1:0]  idx;
    logic              evt;
    logic [STAT_W-1:0] evtBits;
  } ctrl_s;
endpackage

// File: rtl/rxexc_ctrl.sv
module rxexc_ctrl
  import rxexc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic        inParErr,
  input  logic        inFrmErr,
  input  logic        inBreak,
  input  logic        inOverrun,
  input  logic        rxTimeout,
  input  logic        cfgParCheck,
  input  logic [1:0]  cfgBrkPolicy,
  input  logic [2:0]  cfgErrPolicy,
  input  logic        fmtIsLead,
  input  logic        outReady,
  output logic        outValid,
  output ctrl_s       ctl
);
  logic busy;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic accept;
  logic brk, frm, par;
  emit_e kind;
  logic [IDX_W-1:0] count;
  logic [STAT_W-1:0] excBits;

  assign inReady  = ~busy;
  assign outValid = busy;
  assign accept   = inValid & ~busy;

  // break dominates every other condition
  assign brk = inBreak;
  assign frm = inFrmErr & ~inBreak;
  assign par = inParErr & cfgParCheck & ~inBreak;

  always_comb begin
    kind    = EMIT_CHAR;
    excBits = '0;
    if (brk) begin
      case (cfgBrkPolicy)
        BRK_NULL: kind = EMIT_NULL;
        BRK_DROP: kind = EMIT_NONE;
        default: begin
          kind = EMIT_NONE;
          excBits[ST_BRK] = 1'b1;
        end
      endcase
    end else if (frm | par) begin
      case (cfgErrPolicy)
        ERR_NULL:   kind = EMIT_NULL;
        ERR_IGNORE: kind = EMIT_CHAR;
        ERR_DROP:   kind = EMIT_NONE;
        ERR_MARK:   kind = EMIT_MARKED;
        default: begin
          kind = EMIT_NONE;
          excBits[ST_FRM] = frm;
          excBits[ST_PAR] = par;
        end
      endcase
    end else if (cfgErrPolicy == ERR_MARK && fmtIsLead) begin
      kind = EMIT_ESCFF;
    end
    excBits[ST_OVR] = inOverrun;
  end

  always_comb begin
    case (kind)
      EMIT_NONE:   count = IDX_W'(0);
      EMIT_ESCFF:  count = IDX_W'(2);
      EMIT_MARKED: count = IDX_W'(3);
      default:     count = IDX_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      idx     <= '0;
      lastIdx <= '0;
    end else if (busy) begin
      if (outReady) begin
        if (idx == lastIdx) busy <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
    end else if (accept && count != '0) begin
      busy    <= 1'b1;
      idx     <= '0;
      lastIdx <= count - IDX_W'(1);
    end
  end

  always_comb begin
    ctl.load    = accept;
    ctl.kind    = kind;
    ctl.idx     = idx;
    ctl.evt     = (accept && excBits != '0) || rxTimeout;
    ctl.evtBits = (accept ? excBits : '0);
    ctl.evtBits[ST_TMO] = rxTimeout;
  end
endmodule

// File: rtl/rxexc_dpath.sv
module rxexc_dpath
  import rxexc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MARK_LEAD = 8'hFF,
  parameter logic [BYTE_W-1:0] MARK_FILL = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic [2:0]        cfgCharLen,
  input  logic              cfgStrip,
  input  ctrl_s             ctl,
  output logic              fmtIsLead,
  output logic [BYTE_W-1:0] outData,
  output logic              excStrobe,
  output logic [STAT_W-1:0] excStatus
);
  localparam int LEN_W = 4;

  logic [LEN_W-1:0]  charW;
  logic [BYTE_W-1:0] keep;
  logic [BYTE_W-1:0] fmt;
  logic [BYTE_W-1:0] seq [SEQ_SLOTS];
  logic [BYTE_W-1:0] seqNext [SEQ_SLOTS];

  assign charW = {1'b0, cfgCharLen} + LEN_W'(1);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    if (i == BYTE_W - 1) begin : g_top
      assign keep[i] = (LEN_W'(i) < charW) & ~cfgStrip;
    end else begin : g_low
      assign keep[i] = LEN_W'(i) < charW;
    end
  end

  assign fmt       = inData & keep;
  assign fmtIsLead = (fmt == MARK_LEAD);

  always_comb begin
    for (int s = 0; s < SEQ_SLOTS; s++) seqNext[s] = '0;
    case (ctl.kind)
      EMIT_CHAR:  seqNext[0] = fmt;
      EMIT_ESCFF: begin
        seqNext[0] = MARK_LEAD;
        seqNext[1] = fmt;
      end
      EMIT_MARKED: begin
        seqNext[0] = MARK_LEAD;
        seqNext[1] = MARK_FILL;
        seqNext[2] = fmt;
      end
      default: seqNext[0] = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SEQ_SLOTS; s++) seq[s] <= '0;
    end else if (ctl.load) begin
      for (int s = 0; s < SEQ_SLOTS; s++) seq[s] <= seqNext[s];
    end
  end

  assign outData = seq[ctl.idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excStrobe <= 1'b0;
      excStatus <= '0;
    end else begin
      excStrobe <= ctl.evt;
      if (ctl.evt) excStatus <= ctl.evtBits;
    end
  end
endmodule

// File: rtl/rxexc_handler.sv
module rxexc_handler
  import rxexc_pkg::*;
#(
  parameter logic [7:0] MARK_LEAD = 8'hFF,
  parameter logic [7:0] MARK_FILL = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inParErr,
  input  logic       inFrmErr,
  input  logic       inBreak,
  input  logic       inOverrun,
  input  logic       rxTimeout,
  input  logic [2:0] cfgCharLen,
  input  logic       cfgParCheck,
  input  logic       cfgStrip,
  input  logic [1:0] cfgBrkPolicy,
  input  logic [2:0] cfgErrPolicy,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       excStrobe,
  output logic [7:0] excStatus
);
  ctrl_s ctl;
  logic  fmtIsLead;

  rxexc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inParErr(inParErr), .inFrmErr(inFrmErr), .inBreak(inBreak),
    .inOverrun(inOverrun), .rxTimeout(rxTimeout), .cfgParCheck(cfgParCheck),
    .cfgBrkPolicy(cfgBrkPolicy), .cfgErrPolicy(cfgErrPolicy),
    .fmtIsLead(fmtIsLead), .outReady(outReady), .outValid(outValid), .ctl(ctl)
  );

  rxexc_dpath #(.MARK_LEAD(MARK_LEAD), .MARK_FILL(MARK_FILL)) u_dpath (
    .clk(clk), .rstN(rstN), .inData(inData), .cfgCharLen(cfgCharLen),
    .cfgStrip(cfgStrip), .ctl(ctl), .fmtIsLead(fmtIsLead),
    .outData(outData), .excStrobe(excStrobe), .excStatus(excStatus)
  );
endmodule

// File: rtl/rxexc_checker.sv
module rxexc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       inFrmErr,
  input logic       inBreak,
  input logic       inOverrun,
  input logic       rxTimeout,
  input logic [2:0] cfgCharLen,
  input logic [1:0] cfgBrkPolicy,
  input logic [2:0] cfgErrPolicy,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       excStrobe,
  input logic [7:0] excStatus
);
  // R12: input side stalled while a sequence is pending
  a_r12_stall_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R12: output byte held under backpressure
  a_r12_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R11: a strobe always carries a cause in the status word
  a_r11_strobe_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> (excStatus != 8'h00));

  // R3: silent break drop yields neither data nor strobe
  a_r3_break_drop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBreak && cfgBrkPolicy == 2'd3 && !inOverrun && !rxTimeout)
      |=> (!outValid && !excStrobe));

  // R6: marked character starts with the lead byte
  a_r6_mark_lead: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inBreak && inFrmErr && cfgErrPolicy == 3'd5)
      |=> (outValid && outData == 8'hFF));

  // R1: five-bit characters carry zero upper bits when no marker can appear
  a_r1_len5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgCharLen == 3'd4 && cfgErrPolicy != 3'd5) |-> (outData[7:5] == 3'b000));
endmodule

bind rxexc_handler rxexc_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inFrmErr(inFrmErr), .inBreak(inBreak), .inOverrun(inOverrun),
  .rxTimeout(rxTimeout), .cfgCharLen(cfgCharLen), .cfgBrkPolicy(cfgBrkPolicy),
  .cfgErrPolicy(cfgErrPolicy), .outValid(outValid), .outReady(outReady),
  .outData(outData), .excStrobe(excStrobe), .excStatus(excStatus)
);

// File: tb/rxexc_handler_test.sv
module rxexc_handler_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [7:0] inData = '0;
  logic inParErr = 1'b0, inFrmErr = 1'b0, inBreak = 1'b0, inOverrun = 1'b0;
  logic rxTimeout = 1'b0;
  logic [2:0] cfgCharLen = 3'd7;
  logic cfgParCheck = 1'b1, cfgStrip = 1'b0;
  logic [1:0] cfgBrkPolicy = 2'd0;
  logic [2:0] cfgErrPolicy = 3'd0;
  logic outValid, outReady = 1'b1;
  logic [7:0] outData;
  logic excStrobe;
  logic [7:0] excStatus;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rxexc_handler uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Send one character, collect the byte sequence and check it.
  task automatic runChar(input string req, input logic [7:0] d,
                         input bit p, input bit f, input bit b, input bit o,
                         input int expN, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input bit expStb, input logic [7:0] expSt);
    logic [7:0] got [4];
    logic [7:0] exp [3];
    int n;
    bit stb;
    logic [7:0] st;
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    @(negedge clk);
    inData = d; inParErr = p; inFrmErr = f; inBreak = b; inOverrun = o; inValid = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0; inParErr = 1'b0; inFrmErr = 1'b0; inBreak = 1'b0; inOverrun = 1'b0;
    stb = excStrobe; st = excStatus; n = 0;
    while (outValid && n < 4) begin
      got[n] = outData;
      n++;
      @(posedge clk); #1;
    end
    chk(n == expN, req, "byte count", n, expN);
    for (int i = 0; i < 3; i++)
      if (i < n && i < expN) chk(got[i] == exp[i], req, $sformatf("byte %0d", i), got[i], exp[i]);
    chk(stb == expStb, req, "strobe", stb, expStb);
    if (expStb) chk(st == expSt, req, "status", st, expSt);
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R12", "reset outValid", outValid, 0);
    chk(inReady == 1'b1, "R12", "reset inReady", inReady, 1);
    chk(excStrobe == 1'b0, "R11", "reset strobe", excStrobe, 0);
    chk(excStatus == 8'h00, "R11", "reset status", excStatus, 0);
  endtask

  task automatic testLength();
    cfgCharLen = 3'd7; runChar("R1", 8'hA5, 0, 0, 0, 0, 1, 8'hA5, 0, 0, 0, 0);
    cfgCharLen = 3'd4; runChar("R1", 8'hFF, 0, 0, 0, 0, 1, 8'h1F, 0, 0, 0, 0);
    cfgCharLen = 3'd5; runChar("R1", 8'hFF, 0, 0, 0, 0, 1, 8'h3F, 0, 0, 0, 0);
    cfgCharLen = 3'd6; runChar("R1", 8'hC3, 0, 0, 0, 0, 1, 8'h43, 0, 0, 0, 0);
    cfgCharLen = 3'd7;
  endtask

  task automatic testStrip();
    cfgStrip = 1'b1; runChar("R2", 8'hC3, 0, 0, 0, 0, 1, 8'h43, 0, 0, 0, 0);
    cfgStrip = 1'b0;
  endtask

  task automatic testBreak();
    cfgBrkPolicy = 2'd0; runChar("R3", 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 1, 8'h01);
    cfgBrkPolicy = 2'd1; runChar("R3", 8'h00, 0, 0, 1, 0, 1, 8'h00, 0, 0, 0, 0);
    cfgBrkPolicy = 2'd3; runChar("R3", 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    cfgBrkPolicy = 2'd2; runChar("R3", 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 1, 8'h01);
    cfgBrkPolicy = 2'd0;
  endtask

  task automatic testErrExc();
    cfgErrPolicy = 3'd0;
    runChar("R4", 8'h61, 1, 0, 0, 0, 0, 0, 0, 0, 1, 8'h04);
    runChar("R4", 8'h61, 0, 1, 0, 0, 0, 0, 0, 0, 1, 8'h02);
    runChar("R4", 8'h61, 1, 1, 0, 0, 0, 0, 0, 0, 1, 8'h06);
    cfgErrPolicy = 3'd6;
    runChar("R4", 8'h61, 0, 1, 0, 0, 0, 0, 0, 0, 1, 8'h02);
  endtask

  task automatic testErrOther();
    cfgErrPolicy = 3'd1; runChar("R5", 8'h55, 1, 0, 0, 0, 1, 8'h00, 0, 0, 0, 0);
    cfgErrPolicy = 3'd2; runChar("R5", 8'h55, 1, 0, 0, 0, 1, 8'h55, 0, 0, 0, 0);
    cfgErrPolicy = 3'd3; runChar("R5", 8'h55, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testMark();
    cfgErrPolicy = 3'd5;
    runChar("R6", 8'h41, 0, 1, 0, 0, 3, 8'hFF, 8'h00, 8'h41, 0, 0);
    cfgStrip = 1'b1;
    runChar("R6", 8'hC1, 1, 0, 0, 0, 3, 8'hFF, 8'h00, 8'h41, 0, 0);
    runChar("R7", 8'hFF, 0, 0, 0, 0, 1, 8'h7F, 0, 0, 0, 0);
    cfgStrip = 1'b0;
    runChar("R7", 8'hFF, 0, 0, 0, 0, 2, 8'hFF, 8'hFF, 0, 0, 0);
  endtask

  task automatic testParOff();
    cfgErrPolicy = 3'd0; cfgParCheck = 1'b0;
    runChar("R8", 8'h33, 1, 0, 0, 0, 1, 8'h33, 0, 0, 0, 0);
    cfgParCheck = 1'b1;
  endtask

  task automatic testBreakWins();
    cfgBrkPolicy = 2'd1; cfgErrPolicy = 3'd5;
    runChar("R9", 8'h00, 1, 1, 1, 0, 1, 8'h00, 0, 0, 0, 0);
    cfgBrkPolicy = 2'd0; cfgErrPolicy = 3'd0;
  endtask

  task automatic testOverrun();
    runChar("R10", 8'h12, 0, 0, 0, 1, 1, 8'h12, 0, 0, 1, 8'h08);
    runChar("R10", 8'h12, 1, 0, 0, 1, 0, 0, 0, 0, 1, 8'h0C);
  endtask

  task automatic testTimeout();
    @(negedge clk); rxTimeout = 1'b1;
    @(posedge clk); #1; rxTimeout = 1'b0;
    chk(excStrobe == 1'b1, "R11", "timeout strobe", excStrobe, 1);
    chk(excStatus == 8'h80, "R11", "timeout status", excStatus, 8'h80);
    @(posedge clk); #1;
    chk(excStrobe == 1'b0, "R11", "strobe one cycle", excStrobe, 0);
    chk(excStatus == 8'h80, "R11", "status held", excStatus, 8'h80);
  endtask

  task automatic testBackpressure();
    logic [7:0] seen [3];
    cfgErrPolicy = 3'd5;
    @(negedge clk); outReady = 1'b0;
    inData = 8'h41; inFrmErr = 1'b1; inValid = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0; inFrmErr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(outValid == 1'b1, "R12", "valid held", outValid, 1);
      chk(outData == 8'hFF, "R12", "data held", outData, 8'hFF);
      chk(inReady == 1'b0, "R12", "input stalled", inReady, 0);
      @(posedge clk); #1;
    end
    @(negedge clk); outReady = 1'b1;
    for (int i = 0; i < 3; i++) begin
      seen[i] = outData;
      if (i < 2) chk(inReady == 1'b0, "R12", "stall mid sequence", inReady, 0);
      @(posedge clk); #1;
    end
    chk(seen[0] == 8'hFF, "R12", "byte 0", seen[0], 8'hFF);
    chk(seen[1] == 8'h00, "R12", "byte 1", seen[1], 8'h00);
    chk(seen[2] == 8'h41, "R12", "byte 2", seen[2], 8'h41);
    chk(inReady == 1'b1, "R12", "ready after sequence", inReady, 1);
    chk(outValid == 1'b0, "R12", "valid after sequence", outValid, 0);
    cfgErrPolicy = 3'd0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    testLength();
    testStrip();
    testBreak();
    testErrExc();
    testErrOther();
    testMark();
    testParOff();
    testBreakWins();
    testOverrun();
    testTimeout();
    testBackpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule